// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the processor-side bus sequence that follows the acceptance of an interrupt request. On an accept strobe it captures the interrupt class, the priority level, the vector address, the stack pointer, the bus width mode, the return PC word and the flag word. It then performs a fixed series of bus accesses. It reads the interrupt information word, pushes the return PC and the flags onto the stack, and reads the two-word vector. Cycles that carry no defined access are idle.

The number of cycles the sequence takes depends on the bus width, on the parity of the vector address and the stack pointer, and on the interrupt class. In the last counted cycle the block pulses `done_o` and presents the new PC, the new stack pointer and the new interrupt priority level. The new priority level follows a per-class rule: it takes the accepted level, it is forced to all ones, or it keeps its old value. Arbitration between sources, instruction completion and the prefetch queue are handled elsewhere.

Top module: `irq_entry_seq`

## Requirements
- R1: Counting the cycle after the accepting clock edge as cycle 1, with x the class extra (R5) and es, ev the stack and vector stretch bits (R3, R4), the accesses are as follows. A read of address 0 occurs in cycle 1. A write to SP-2 occurs in cycle 4+x, and a write to SP-4 in cycle 6+x+es. A read of the vector address occurs in cycle 15+x+es, and a read of vector+2 in cycle 17+x+es+ev.
- R2: The write to SP-2 carries the return PC word and the write to SP-4 carries the flag word, both as captured at acceptance.
- R3: With the 16-bit bus (`byte_bus_i`=0), es is bit 0 of SP and ev is bit 0 of the vector address. The sequence therefore lasts 18 cycles when both are even, 19 when exactly one is odd and 20 when both are odd, plus x.
- R4: With the 8-bit bus (`byte_bus_i`=1), es and ev are both 1, so the sequence lasts 20 cycles plus x regardless of parity.
- R5: The class code sits in `irq_class_i`. Code 5 (debugger) gives x=2, codes 3 (address match) and 4 (single step) give x=1, and all other codes give x=0.
- R6: Code 0 (maskable) loads the new priority level from `irq_level_i`.
- R7: Code 2 (watchdog, non-maskable, oscillation-stop or voltage-detect) loads the new priority level with all ones (7).
- R8: Codes 1 (software), 3, 4, 5 and the reserved codes 6 and 7 leave the priority level unchanged.
- R9: `done_o` is high for exactly one cycle, the last counted cycle 18+x+es+ev. In that cycle `pc_o` equals {word read at vector+2, word read at vector} and `sp_o` equals SP-4.
- R10: An accept strobe during a sequence, including its done cycle, is ignored. `pc_o`, `sp_o` and `ipl_o` change only in a cycle where `done_o` is high.
- R11: In every cycle without a defined access, `rd_o` and `wr_o` are low and `addr_o` and `wdata_o` are zero. A read and a write never occur together.
- R12: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| accept_i | input | 1 | Interrupt accepted; starts a sequence when idle |
| irq_class_i | input | 3 | Interrupt class code |
| irq_level_i | input | LW | Priority level of the accepted interrupt |
| vec_addr_i | input | AW | Vector address |
| sp_i | input | AW | Stack pointer at acceptance |
| byte_bus_i | input | 1 | 1 selects the 8-bit bus timing |
| ret_pc_i | input | DW | Return PC word to push |
| flags_i | input | DW | Flag word to push |
| rdata_i | input | DW | Read data, sampled at the end of a read cycle |
| addr_o | output | AW | Bus address |
| wdata_o | output | DW | Write data |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| done_o | output | 1 | Last cycle of the sequence |
| pc_o | output | 2*DW | New PC built from the vector |
| sp_o | output | AW | New stack pointer |
| ipl_o | output | LW | Current interrupt priority level |

## Verification
The bench sweeps every class code over both bus widths and all four parity pairs, and it checks the slot of every access and the length of the run cycle by cycle. A design that dropped a stretch cycle, or applied parity penalties on the 8-bit bus, would put its late reads and its done pulse one cycle early or late. A design that swapped the vector halves would build a wrong PC. A design that confused the priority rules would show a wrong level after a forced class, or after a class that must keep the level. Half of the runs inject a second accept with different inputs mid-sequence, and a design that relatched would show a wrong stack pointer or a wrong length.

// File: rtl/irq_entry_pkg.sv
// Shared class codes and cycle constants of the interrupt entry sequencer.
package irq_entry_pkg;
    typedef enum logic [2:0] {
        IC_MASKABLE   = 3'd0,
        IC_SOFTWARE   = 3'd1,
        IC_FORCED     = 3'd2,
        IC_ADDR_MATCH = 3'd3,
        IC_STEP       = 3'd4,
        IC_DEBUG      = 3'd5,
        IC_RSVD6      = 3'd6,
        IC_RSVD7      = 3'd7
    } irq_class_t;

    localparam int CNT_W       = 5;   // holds up to 22 cycles
    localparam int BASE_CYCLES = 18;

    // Extra cycles a class adds to the base sequence.
    function automatic logic [1:0] class_extra(irq_class_t c);
        case (c)
            IC_DEBUG:               return 2'd2;
            IC_ADDR_MATCH, IC_STEP: return 2'd1;
            default:                return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/irq_entry_sched.sv
// Slot calculator: from the captured class, parity bits and bus width it
// derives the cycle of every bus access and the total length.
// Assumes the inputs are stable for the whole sequence (they are latched).
module irq_entry_sched
    import irq_entry_pkg::*;
(
    input  irq_class_t          cls,
    input  logic                vec_lsb,
    input  logic                sp_lsb,
    input  logic                byte_bus,
    output logic [CNT_W-1:0]    t_wr_hi,
    output logic [CNT_W-1:0]    t_wr_lo,
    output logic [CNT_W-1:0]    t_rd_lo,
    output logic [CNT_W-1:0]    t_rd_hi,
    output logic [CNT_W-1:0]    total
);
    logic [CNT_W-1:0] x, es, ev;

    // Stretch bits: the narrow bus always pays both, the wide bus pays parity.
    always_comb begin
        x  = CNT_W'(class_extra(cls));
        es = CNT_W'(byte_bus | sp_lsb);
        ev = CNT_W'(byte_bus | vec_lsb);
        t_wr_hi = CNT_W'(4) + x;
        t_wr_lo = CNT_W'(6) + x + es;
        t_rd_lo = CNT_W'(15) + x + es;
        t_rd_hi = CNT_W'(BASE_CYCLES - 1) + x + es + ev;
        total   = CNT_W'(BASE_CYCLES) + x + es + ev;
    end
endmodule

// File: rtl/irq_entry_ipl.sv
// Priority level register: on load it applies the class rule
// (accepted level, forced all ones, or unchanged).
module irq_entry_ipl
    import irq_entry_pkg::*;
#(
    parameter int LW = 3
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  irq_class_t    cls,
    input  logic [LW-1:0] level,
    output logic [LW-1:0] ipl
);
    // Update the level according to the class of the finishing sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipl <= '0;
        end else if (load) begin
            case (cls)
                IC_MASKABLE: ipl <= level;
                IC_FORCED:   ipl <= '1;
                default:     ipl <= ipl;
            endcase
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry sequencer top. Latches the request on accept, counts the
// sequence cycles, drives the bus slots from the schedule, and loads the
// new PC, SP and level so they appear in the done cycle.
// Assumes zero-wait reads: rdata_i is valid at the end of a read cycle.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int LW = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [2:0]        irq_class_i,
    input  logic [LW-1:0]     irq_level_i,
    input  logic [AW-1:0]     vec_addr_i,
    input  logic [AW-1:0]     sp_i,
    input  logic              byte_bus_i,
    input  logic [DW-1:0]     ret_pc_i,
    input  logic [DW-1:0]     flags_i,
    input  logic [DW-1:0]     rdata_i,
    output logic [AW-1:0]     addr_o,
    output logic [DW-1:0]     wdata_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              done_o,
    output logic [2*DW-1:0]   pc_o,
    output logic [AW-1:0]     sp_o,
    output logic [LW-1:0]     ipl_o
);
    irq_class_t       cls_q;
    logic [LW-1:0]    lvl_q;
    logic [AW-1:0]    vec_q, sp_q, spn_q;
    logic             byte_q, busy_q;
    logic [DW-1:0]    rpc_q, flg_q, vlo_q;
    logic [2*DW-1:0]  pc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] t_wr_hi, t_wr_lo, t_rd_lo, t_rd_hi, total;
    logic             start, last, slot_info, slot_whi, slot_wlo, slot_rlo, slot_rhi;

    irq_entry_sched u_sched (
        .cls      (cls_q),
        .vec_lsb  (vec_q[0]),
        .sp_lsb   (sp_q[0]),
        .byte_bus (byte_q),
        .t_wr_hi  (t_wr_hi),
        .t_wr_lo  (t_wr_lo),
        .t_rd_lo  (t_rd_lo),
        .t_rd_hi  (t_rd_hi),
        .total    (total)
    );

    // Slot decode of the current cycle.
    always_comb begin
        start     = accept_i && !busy_q;
        last      = busy_q && (cnt_q == total);
        slot_info = busy_q && (cnt_q == CNT_W'(1));
        slot_whi  = busy_q && (cnt_q == t_wr_hi);
        slot_wlo  = busy_q && (cnt_q == t_wr_lo);
        slot_rlo  = busy_q && (cnt_q == t_rd_lo);
        slot_rhi  = busy_q && (cnt_q == t_rd_hi);
    end

    // Capture the request on acceptance; later accepts are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q  <= IC_MASKABLE;
            lvl_q  <= '0;
            vec_q  <= '0;
            sp_q   <= '0;
            byte_q <= 1'b0;
            rpc_q  <= '0;
            flg_q  <= '0;
        end else if (start) begin
            cls_q  <= irq_class_t'(irq_class_i);
            lvl_q  <= irq_level_i;
            vec_q  <= vec_addr_i;
            sp_q   <= sp_i;
            byte_q <= byte_bus_i;
            rpc_q  <= ret_pc_i;
            flg_q  <= flags_i;
        end
    end

    // Sequence cycle counter: 1 in the first cycle, total in the done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
        end else if (last) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    // Hold the low vector word, then form PC and SP for the done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vlo_q <= '0;
            pc_q  <= '0;
            spn_q <= '0;
        end else begin
            if (slot_rlo) vlo_q <= rdata_i;
            if (slot_rhi) begin
                pc_q  <= {rdata_i, vlo_q};
                spn_q <= sp_q - AW'(4);
            end
        end
    end

    irq_entry_ipl #(.LW(LW)) u_ipl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (slot_rhi),
        .cls   (cls_q),
        .level (lvl_q),
        .ipl   (ipl_o)
    );

    // Bus drive: one defined access per slot, idle otherwise.
    always_comb begin
        rd_o    = slot_info || slot_rlo || slot_rhi;
        wr_o    = slot_whi || slot_wlo;
        addr_o  = '0;
        wdata_o = '0;
        if (slot_whi) begin
            addr_o  = sp_q - AW'(2);
            wdata_o = rpc_q;
        end else if (slot_wlo) begin
            addr_o  = sp_q - AW'(4);
            wdata_o = flg_q;
        end else if (slot_rlo) begin
            addr_o  = vec_q;
        end else if (slot_rhi) begin
            addr_o  = vec_q + AW'(2);
        end
    end

    assign done_o = last;
    assign pc_o   = pc_q;
    assign sp_o   = spn_q;
endmodule

// File: rtl/irq_entry_seq_chk.sv
// Property checker for irq_entry_seq, attached by bind below.
module irq_entry_seq_chk
    import irq_entry_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int LW = 3
)(
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            rd,
    input logic            wr,
    input logic [AW-1:0]   addr,
    input logic [AW-1:0]   sp_base,
    input irq_class_t      cls,
    input logic [LW-1:0]   ipl,
    input logic [AW-1:0]   sp_new,
    input logic [2*DW-1:0] pc_new
);
    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));
    assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd && !wr));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_write_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (addr == sp_base - AW'(2) || addr == sp_base - AW'(4)));
    assert_sp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp_new) |-> done);
    assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_new) |-> done);
    assert_ipl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ipl) |-> done);
    assert_ipl_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls == IC_FORCED) |-> (ipl == '1));
    assert_ipl_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls != IC_MASKABLE && cls != IC_FORCED) |-> $stable(ipl));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.AW(AW), .DW(DW), .LW(LW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_q),
    .done    (done_o),
    .rd      (rd_o),
    .wr      (wr_o),
    .addr    (addr_o),
    .sp_base (sp_q),
    .cls     (cls_q),
    .ipl     (ipl_o),
    .sp_new  (sp_o),
    .pc_new  (pc_o)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int LW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            accept_i = 1'b0;
    logic [2:0]      irq_class_i = '0;
    logic [LW-1:0]   irq_level_i = '0;
    logic [AW-1:0]   vec_addr_i = '0;
    logic [AW-1:0]   sp_i = '0;
    logic            byte_bus_i = 1'b0;
    logic [DW-1:0]   ret_pc_i = '0;
    logic [DW-1:0]   flags_i = '0;
    logic [DW-1:0]   rdata_i;
    logic [AW-1:0]   addr_o;
    logic [DW-1:0]   wdata_o;
    logic            rd_o, wr_o, done_o;
    logic [2*DW-1:0] pc_o;
    logic [AW-1:0]   sp_o;
    logic [LW-1:0]   ipl_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [LW-1:0] model_ipl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: read data is an arithmetic function of the address.
    function automatic logic [DW-1:0] mem(logic [AW-1:0] a);
        return DW'(a * 16'd3 + 16'h1234);
    endfunction
    assign rdata_i = mem(addr_o);

    irq_entry_seq #(.AW(AW), .DW(DW), .LW(LW)) i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .irq_class_i(irq_class_i),
        .irq_level_i(irq_level_i), .vec_addr_i(vec_addr_i), .sp_i(sp_i),
        .byte_bus_i(byte_bus_i), .ret_pc_i(ret_pc_i), .flags_i(flags_i),
        .rdata_i(rdata_i), .addr_o(addr_o), .wdata_o(wdata_o), .rd_o(rd_o),
        .wr_o(wr_o), .done_o(done_o), .pc_o(pc_o), .sp_o(sp_o), .ipl_o(ipl_o)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One full sequence with expected slots computed from the requirements.
    task automatic run_one(int c, logic [LW-1:0] lvl, logic [AW-1:0] vec,
                           logic [AW-1:0] sp, bit bb, bit inject);
        int x, es, ev, n, done_k, sched_err, wd_err;
        logic [DW-1:0] rpc, flg;
        string lenreq;
        x  = (c == 5) ? 2 : ((c == 3 || c == 4) ? 1 : 0);     // R5
        es = bb ? 1 : int'(sp[0]);                             // R3, R4
        ev = bb ? 1 : int'(vec[0]);
        n  = 18 + x + es + ev;
        rpc = DW'(vec ^ 16'h5A5A);
        flg = DW'(sp ^ 16'h0F0F);
        lenreq = bb ? "R4" : (x != 0 ? "R5" : "R3");
        sched_err = 0; wd_err = 0; done_k = 0;
        @(negedge clk);
        irq_class_i = 3'(c); irq_level_i = lvl; vec_addr_i = vec; sp_i = sp;
        byte_bus_i = bb; ret_pc_i = rpc; flags_i = flg; accept_i = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            bit er, ew;
            logic [AW-1:0] ea;
            logic [DW-1:0] ed;
            @(negedge clk);
            accept_i = 1'b0;
            er = (k == 1) || (k == 15 + x + es) || (k == 17 + x + es + ev);   // R1
            ew = (k == 4 + x) || (k == 6 + x + es);
            ea = '0; ed = '0;                                              // R11
            if (k == 4 + x)               begin ea = sp - 16'd2; ed = rpc; end   // R2
            else if (k == 6 + x + es)     begin ea = sp - 16'd4; ed = flg; end
            else if (k == 15 + x + es)      ea = vec;
            else if (k == 17 + x + es + ev) ea = vec + 16'd2;
            if (rd_o !== er || wr_o !== ew || addr_o !== ea) sched_err++;
            if (wdata_o !== ed) wd_err++;
            if (done_o) begin done_k = k; break; end
            if (inject && k == 5) begin            // R10: second accept mid-run
                accept_i = 1'b1; sp_i = sp ^ 16'h0100; irq_class_i = 3'd2;
                vec_addr_i = vec ^ 16'h0001; byte_bus_i = ~bb;
            end
        end
        check(sched_err == 0, "R1/R11", "schedule mismatches", sched_err, 0);
        check(wd_err == 0, "R2", "write data mismatches", wd_err, 0);
        check(done_k == n, lenreq, "done cycle", done_k, n);
        check(pc_o == {mem(vec + 16'd2), mem(vec)}, "R9", "new pc",
              pc_o, {mem(vec + 16'd2), mem(vec)});
        check(sp_o == sp - 16'd4, "R9", "new sp", sp_o, sp - 16'd4);
        if (c == 0)      model_ipl = lvl;        // R6
        else if (c == 2) model_ipl = '1;         // R7
        check(ipl_o == model_ipl, (c == 0) ? "R6" : ((c == 2) ? "R7" : "R8"),
              "ipl", ipl_o, model_ipl);
        @(negedge clk);
        check(!done_o && !rd_o && !wr_o, "R9", "done single cycle", done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(addr_o == 0 && wdata_o == 0 && !rd_o && !wr_o && !done_o &&
              pc_o == 0 && sp_o == 0 && ipl_o == 0, "R12", "reset outputs",
              {rd_o, wr_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 8; c++)
            for (int b = 0; b < 2; b++)
                for (int v = 0; v < 2; v++)
                    for (int s = 0; s < 2; s++)
                        run_one(c, LW'(c + v + 2 * s + 3 * b + 1),
                                AW'(16'h04A0 + c * 8 + v),
                                AW'(16'h2F00 + c * 4 + b * 64 + s),
                                b[0], (v ^ s ^ b) != 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule